// File: doc/BRIEF.md
# Watchdog Counter with Low-Power Halt and Timed Resume

This block is a watchdog counter that counts enable pulses from one of two sources: a peripheral-clock tick or the rising edges of a slow internal oscillator enable. When the count passes a programmed terminal value, the counter wraps to zero and raises a one-cycle overflow pulse, which the chip uses as its reset request. Software restarts the count with a clear strobe. The same strobe also chooses the count source.

A stop request puts the block into a halted state that matches the chip's low-power stop. In this state the count is frozen, and no tick from either source and no clear strobe has any effect. A wake event does not restart counting at once. If the main clock is a crystal or ceramic resonator, the block first waits a selectable settling time counted in system-clock cycles. It then waits a fixed number of complete slow-oscillator periods. After that, counting resumes from the held value on the source used before the halt. A new stop request during either wait sends the block back to the halted state, and the whole wake sequence runs again.

Top module: `wdog_stop_resume`

## Requirements
- R1: After reset, count is 0, overflow is 0, running is 1 and the count source is the peripheral tick.
- R2: While running, a cycle with the peripheral source selected and periph_tick high adds 1 to count. With the slow source selected, only a 0-to-1 transition of slow_clk_en adds 1, so a level held high for several cycles counts once.
- R3: A source tick that arrives while count equals TOP_VAL (default 255) sets count to 0 and raises overflow for exactly one cycle.
- R4: A stop_req cycle blocks any tick in that same cycle and drops running from the next cycle on. While halted, count does not change, whatever either source does.
- R5: After stop_release with xtal_main = 0, running stays 0 until 8 rising edges of slow_clk_en have occurred. Running rises after the 8th edge, and counting continues from the held count.
- R6: With xtal_main = 1, a settling wait of 2^E system-clock cycles comes before the 8-edge delay, where stab_sel 0/1/2/3 gives E = 10/12/15/17. Slow edges that occur during the settling wait do not count toward the 8.
- R7: A stop_req during the settling wait or the 8-edge delay returns the block to the halted state with the count held. The next stop_release starts the full sequence again.
- R8: sw_clear in a running cycle sets count to 0 and loads the source from src_sel (0 = peripheral tick, 1 = slow edge). The clear wins over a tick in the same cycle. When the block is not running, sw_clear changes neither the count nor the source.
- R9: The count source in force before a stop is still in force after resume, even if src_sel changed during the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_clk_en | input | 1 | Slow oscillator enable level; its rising edges are counted |
| periph_tick | input | 1 | Peripheral-clock count enable |
| src_sel | input | 1 | Source choice taken on clear: 0 peripheral, 1 slow |
| stop_req | input | 1 | Enter the halted (stop) state |
| stop_release | input | 1 | Wake event that leaves the halted state |
| xtal_main | input | 1 | Main clock is a crystal or ceramic resonator |
| stab_sel | input | 2 | Settling time select (2^10, 2^12, 2^15, 2^17 cycles) |
| sw_clear | input | 1 | Software clear and source load strobe |
| count | output | CNT_W | Current watchdog count |
| overflow | output | 1 | One-cycle reset request on wrap |
| running | output | 1 | High only while counting is allowed |

## Verification
The case that matters is a stop request arriving in the same cycle as the tick that would make the counter wrap. The bench advances the count to TOP_VAL and then asserts stop_req and periph_tick together. It expects count to stay at TOP_VAL, no overflow pulse, and running low on the next cycle. After a full wake sequence, one more tick must then produce the wrap and the pulse. The bench also puts a clear and a tick in the same cycle and expects the clear to win.

// File: rtl/wdsr_pkg.sv
package wdsr_pkg;

  // Sequencer states: counting, frozen, resonator settling, slow-edge delay
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DELAY  = 2'd3
  } wdsr_state_e;

endpackage

// File: rtl/wdsr_edge.sv
module wdsr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic edge_pulse
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  // Only a low-to-high transition qualifies, so a complete slow period is counted once
  assign edge_pulse = level & ~lvl_q;

endmodule

// File: rtl/wdsr_seq.sv
module wdsr_seq
  import wdsr_pkg::*;
#(
  parameter int unsigned EXP0         = 10,
  parameter int unsigned EXP1         = 12,
  parameter int unsigned EXP2         = 15,
  parameter int unsigned EXP3         = 17,
  parameter int unsigned RESUME_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       stop_release,
  input  logic       xtal_main,
  input  logic [1:0] stab_sel,
  input  logic       slow_edge,
  output logic       run_ok
);

  // EXP3 is the longest settling choice and sizes the down-counter
  localparam int unsigned STAB_W = EXP3;
  localparam int unsigned DLY_W  = $clog2(RESUME_TICKS + 1);
  localparam logic [STAB_W-1:0] LOAD0 = STAB_W'((64'd1 << EXP0) - 64'd1);
  localparam logic [STAB_W-1:0] LOAD1 = STAB_W'((64'd1 << EXP1) - 64'd1);
  localparam logic [STAB_W-1:0] LOAD2 = STAB_W'((64'd1 << EXP2) - 64'd1);
  localparam logic [STAB_W-1:0] LOAD3 = STAB_W'((64'd1 << EXP3) - 64'd1);
  localparam logic [DLY_W-1:0]  DLY_LAST = DLY_W'(RESUME_TICKS - 1);

  wdsr_state_e       st_q, st_d;
  logic [STAB_W-1:0] settle_q, settle_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [STAB_W-1:0] settle_load;

  always_comb begin
    case (stab_sel)
      2'd0:    settle_load = LOAD0;
      2'd1:    settle_load = LOAD1;
      2'd2:    settle_load = LOAD2;
      default: settle_load = LOAD3;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    settle_d = settle_q;
    dly_d    = dly_q;
    case (st_q)
      ST_RUN: begin
        if (stop_req) st_d = ST_HALT;
      end
      ST_HALT: begin
        // a simultaneous stop request keeps the block halted
        if (stop_release && !stop_req) begin
          if (xtal_main) begin
            st_d     = ST_SETTLE;
            settle_d = settle_load;
          end else begin
            st_d  = ST_DELAY;
            dly_d = '0;
          end
        end
      end
      ST_SETTLE: begin
        if (stop_req) begin
          st_d = ST_HALT;
        end else if (settle_q == '0) begin
          st_d  = ST_DELAY;
          dly_d = '0;
        end else begin
          settle_d = settle_q - 1'b1;
        end
      end
      ST_DELAY: begin
        if (stop_req) begin
          st_d = ST_HALT;
        end else if (slow_edge) begin
          if (dly_q == DLY_LAST) st_d = ST_RUN;
          else                   dly_d = dly_q + 1'b1;
        end
      end
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      settle_q <= '0;
      dly_q    <= '0;
    end else begin
      st_q     <= st_d;
      settle_q <= settle_d;
      dly_q    <= dly_d;
    end
  end

  assign run_ok = (st_q == ST_RUN);

endmodule

// File: rtl/wdsr_count.sv
module wdsr_count #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TOP_VAL = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic             stop_req,
  input  logic             sw_clear,
  input  logic             src_sel,
  input  logic             periph_tick,
  input  logic             slow_edge,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(TOP_VAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             src_q, src_d;
  logic             live;
  logic             tick;

  // a stop request takes effect in its own cycle
  assign live = run_ok & ~stop_req;
  assign tick = src_q ? slow_edge : periph_tick;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    src_d = src_q;
    if (live && sw_clear) begin
      cnt_d = '0;
      src_d = src_sel;
    end else if (live && tick) begin
      if (cnt_q == TOP) begin
        cnt_d = '0;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      src_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      src_q <= src_d;
    end
  end

  assign count    = cnt_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/wdog_stop_resume.sv
module wdog_stop_resume #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned TOP_VAL      = 255,
  parameter int unsigned EXP0         = 10,
  parameter int unsigned EXP1         = 12,
  parameter int unsigned EXP2         = 15,
  parameter int unsigned EXP3         = 17,
  parameter int unsigned RESUME_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk_en,
  input  logic             periph_tick,
  input  logic             src_sel,
  input  logic             stop_req,
  input  logic             stop_release,
  input  logic             xtal_main,
  input  logic [1:0]       stab_sel,
  input  logic             sw_clear,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             running
);

  logic rst_meta_n;
  logic rst_sync_n;
  logic slow_edge;
  logic run_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  wdsr_edge i_edge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .level      (slow_clk_en),
    .edge_pulse (slow_edge)
  );

  wdsr_seq #(
    .EXP0         (EXP0),
    .EXP1         (EXP1),
    .EXP2         (EXP2),
    .EXP3         (EXP3),
    .RESUME_TICKS (RESUME_TICKS)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .stop_req     (stop_req),
    .stop_release (stop_release),
    .xtal_main    (xtal_main),
    .stab_sel     (stab_sel),
    .slow_edge    (slow_edge),
    .run_ok       (run_ok)
  );

  wdsr_count #(
    .CNT_W   (CNT_W),
    .TOP_VAL (TOP_VAL)
  ) i_count (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run_ok      (run_ok),
    .stop_req    (stop_req),
    .sw_clear    (sw_clear),
    .src_sel     (src_sel),
    .periph_tick (periph_tick),
    .slow_edge   (slow_edge),
    .count       (count),
    .overflow    (overflow)
  );

  assign running = run_ok;

endmodule

// File: rtl/wdog_stop_resume_chk.sv
module wdog_stop_resume_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             slow_clk_en,
  input logic             running,
  input logic             overflow,
  input logic [CNT_W-1:0] count
);

  // R4: nothing moves the count while the block is not running
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(count));

  // R4: a stop request freezes the count at once and drops running
  assert_stop_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stop_req) |=> (!running && $stable(count)));

  // R3: the wrap pulse lasts one cycle and coincides with a zero count
  assert_ovf_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (count == '0) ##1 !overflow);

  // R3: a wrap can only come from a running cycle
  assert_ovf_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(running));

  // R2: the count only holds, steps by one, or returns to zero
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (count == $past(count) || count == ($past(count) + 1'b1) || count == '0));

  // R5: running rises only on a cycle that followed a slow enable pulse
  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(slow_clk_en));

endmodule

bind wdog_stop_resume wdog_stop_resume_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .stop_req    (stop_req),
  .slow_clk_en (slow_clk_en),
  .running     (running),
  .overflow    (overflow),
  .count       (count)
);

// File: tb/test_wdog_stop_resume.sv
`timescale 1ns/1ps
module test_wdog_stop_resume;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk_en = 1'b0;
  logic       periph_tick = 1'b0;
  logic       src_sel = 1'b0;
  logic       stop_req = 1'b0;
  logic       stop_release = 1'b0;
  logic       xtal_main = 1'b0;
  logic [1:0] stab_sel = 2'd0;
  logic       sw_clear = 1'b0;
  logic [7:0] count;
  logic       overflow;
  logic       running;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdog_stop_resume i_wdog_stop_resume (
    .clk(clk), .rst_n(rst_n), .slow_clk_en(slow_clk_en), .periph_tick(periph_tick),
    .src_sel(src_sel), .stop_req(stop_req), .stop_release(stop_release),
    .xtal_main(xtal_main), .stab_sel(stab_sel), .sw_clear(sw_clear),
    .count(count), .overflow(overflow), .running(running)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ptick();
    periph_tick = 1'b1; @(negedge clk); periph_tick = 1'b0;
  endtask

  task automatic spulse();
    slow_clk_en = 1'b1; @(negedge clk); slow_clk_en = 1'b0; @(negedge clk);
  endtask

  task automatic do_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic do_release();
    stop_release = 1'b1; @(negedge clk); stop_release = 1'b0;
  endtask

  task automatic do_clear(input logic s);
    src_sel = s; sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count after reset", count, 0);
    chk("R1", "overflow after reset", overflow, 0);
    chk("R1", "running after reset", running, 1);
    ptick();
    chk("R1", "peripheral source by default", count, 1);
  endtask

  task automatic t_periph();
    do_clear(1'b0);
    for (int i = 0; i < 5; i++) ptick();
    step(3);
    chk("R2", "five peripheral ticks", count, 5);
  endtask

  task automatic t_slow_src();
    do_clear(1'b1);
    chk("R8", "clear to zero", count, 0);
    slow_clk_en = 1'b1; step(3); slow_clk_en = 1'b0; step(1);
    chk("R2", "held slow level counts once", count, 1);
    ptick();
    chk("R8", "peripheral tick ignored on slow source", count, 1);
    spulse();
    chk("R2", "second slow edge", count, 2);
  endtask

  task automatic t_clear_wins();
    src_sel = 1'b0; sw_clear = 1'b1; periph_tick = 1'b1; slow_clk_en = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0; periph_tick = 1'b0; slow_clk_en = 1'b0;
    chk("R8", "clear beats same-cycle tick", count, 0);
  endtask

  task automatic t_overflow();
    do_clear(1'b0);
    for (int i = 0; i < 255; i++) ptick();
    chk("R3", "count at top", count, 255);
    chk("R3", "no pulse before wrap", overflow, 0);
    ptick();
    chk("R3", "wrap to zero", count, 0);
    chk("R3", "pulse on wrap", overflow, 1);
    step(1);
    chk("R3", "pulse lasts one cycle", overflow, 0);
  endtask

  task automatic t_stop_hold();
    do_clear(1'b0);
    for (int i = 0; i < 3; i++) ptick();
    stop_req = 1'b1; periph_tick = 1'b1; @(negedge clk); stop_req = 1'b0; periph_tick = 1'b0;
    chk("R4", "same-cycle tick blocked", count, 3);
    chk("R4", "running low in stop", running, 0);
    ptick(); ptick(); spulse(); spulse();
    chk("R4", "no advance while halted", count, 3);
    do_clear(1'b1);
    chk("R8", "clear ignored while halted", count, 3);
  endtask

  task automatic t_resume_fast();
    xtal_main = 1'b0;
    do_release();
    for (int i = 0; i < 7; i++) spulse();
    chk("R5", "still halted after 7 edges", running, 0);
    spulse();
    chk("R5", "running after 8th edge", running, 1);
    chk("R5", "count held across stop", count, 3);
    ptick();
    chk("R8", "source unchanged by ignored clear", count, 4);
  endtask

  task automatic t_stop_in_delay();
    do_stop();
    do_release();
    for (int i = 0; i < 4; i++) spulse();
    do_stop();
    for (int i = 0; i < 4; i++) spulse();
    chk("R7", "stop during delay halts again", running, 0);
    do_release();
    for (int i = 0; i < 4; i++) spulse();
    chk("R7", "delay restarted from zero", running, 0);
    for (int i = 0; i < 4; i++) spulse();
    chk("R7", "resume after full redo", running, 1);
    chk("R7", "count held", count, 4);
  endtask

  task automatic t_settle();
    do_stop();
    xtal_main = 1'b1; stab_sel = 2'd0;
    do_release();
    for (int i = 0; i < 8; i++) spulse();
    chk("R6", "edges during settling not counted", running, 0);
    step(1010);
    for (int i = 0; i < 7; i++) spulse();
    chk("R6", "7 edges after 1024-cycle wait", running, 0);
    spulse();
    chk("R6", "running after settle plus 8 edges", running, 1);
    do_stop();
    stab_sel = 2'd1;
    do_release();
    step(1100);
    for (int i = 0; i < 8; i++) spulse();
    chk("R6", "longer select still settling", running, 0);
    step(3000);
    for (int i = 0; i < 8; i++) spulse();
    chk("R6", "running after 4096-cycle wait", running, 1);
    chk("R6", "count held through settling", count, 4);
    xtal_main = 1'b0;
  endtask

  task automatic t_source_kept();
    do_clear(1'b1);
    spulse();
    chk("R9", "slow source counting", count, 1);
    do_stop();
    src_sel = 1'b0;
    do_release();
    for (int i = 0; i < 8; i++) spulse();
    chk("R9", "resumed", running, 1);
    ptick();
    chk("R9", "peripheral tick ignored after resume", count, 1);
    spulse();
    chk("R9", "slow source kept", count, 2);
  endtask

  task automatic t_stop_at_top();
    do_clear(1'b0);
    for (int i = 0; i < 255; i++) ptick();
    stop_req = 1'b1; periph_tick = 1'b1; @(negedge clk); stop_req = 1'b0; periph_tick = 1'b0;
    chk("R4", "wrap tick blocked by stop", count, 255);
    chk("R3", "no pulse when stop blocks wrap", overflow, 0);
    do_release();
    for (int i = 0; i < 8; i++) spulse();
    ptick();
    chk("R3", "wrap after resume", count, 0);
    chk("R3", "pulse after resume", overflow, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_periph();
    t_slow_src();
    t_clear_wins();
    t_overflow();
    t_stop_hold();
    t_resume_fast();
    t_stop_in_delay();
    t_settle();
    t_source_kept();
    t_stop_at_top();
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule